// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This block resolves what happens when a return-from-trap instruction executes. On a request it reads the current program counter, the processor status word and the debug-state flag. It also reads the instruction's one-bit debug selector, the saved trap PC and saved debug PC, and the two saved debug status bits. From these it produces the next program counter, a status-word write, a debug-state clear, a halt request and an illegal-instruction request.

Four cases are tested in a fixed order. A return attempted in user mode goes to PC+4, and it also asks for a halt when exceptions are disabled. A return in supervisor mode with exceptions still enabled is illegal. A normal return restores from the saved trap PC. A debug return restores from the debug save registers and leaves debug state. Every other combination falls through to PC+4 with no side effect. The status word is bit-mapped: bit 0 is the exception-enable bit, bit 1 is the supervisor bit, and bit 2 is the previous-supervisor bit. The remaining bits are carried unchanged.

Top module: `trap_return_unit`

## Requirements
- R1: After synchronous reset, rsp_valid, stat_we, dbg_clear, halt_req and illegal_req are all 0.
- R2: A request on req_valid produces rsp_valid exactly two clock edges later, for one cycle. stat_we, dbg_clear, halt_req and illegal_req are only ever high while rsp_valid is high, so each is a one-cycle pulse.
- R3: With the supervisor bit (status bit 1) clear, next_pc is PC+4 and halt_req equals the inverse of the enable bit (status bit 0). stat_we, illegal_req and dbg_clear stay 0.
- R4: With the supervisor bit set and the enable bit set, illegal_req is 1 and next_pc is PC+4. halt_req, stat_we and dbg_clear stay 0.
- R5: With supervisor set, enable clear, debug state 0 and debug selector 0, next_pc is the saved trap PC and stat_we is 1. In stat_wdata, bit 0 is 1 and bit 1 equals status bit 2. Every other bit equals the incoming status, and dbg_clear is 0.
- R6: With supervisor set, enable clear, debug state 1 and debug selector 1, next_pc is the saved debug PC, and stat_we and dbg_clear are 1. In stat_wdata, bit 0 takes the saved debug enable and bit 1 takes the saved debug supervisor. Every other bit equals the incoming status.
- R7: With supervisor set, enable clear, and the debug state differing from the debug selector, next_pc is PC+4 and no strobe is raised.
- R8: PC+4 wraps modulo 2^ADDR_W.
- R9: At most one of halt_req, illegal_req and stat_we is high in any cycle, following the priority user mode, then enabled supervisor, then normal return, then debug return.
- R10: Input values presented while req_valid is 0 produce no rsp_valid and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Return-from-trap request |
| cur_pc | input | ADDR_W | PC of the return instruction |
| status_in | input | STAT_W | Current status word |
| in_debug | input | 1 | Core is in debug state |
| dbg_sel | input | 1 | Debug selector field of the instruction |
| trap_pc | input | ADDR_W | Saved trap PC |
| dbg_pc | input | ADDR_W | Saved debug PC |
| dbg_save_en | input | 1 | Saved debug enable bit |
| dbg_save_sup | input | 1 | Saved debug supervisor bit |
| rsp_valid | output | 1 | Result valid |
| next_pc | output | ADDR_W | Next program counter |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | STAT_W | Updated status word |
| dbg_clear | output | 1 | Leave debug state |
| halt_req | output | 1 | Halt request |
| illegal_req | output | 1 | Illegal-instruction request |

## Verification
Every result arrives two rising edges after the request edge: one edge to capture the inputs and one to register the decision. The bench raises req_valid at a falling edge and samples at the second falling edge after that. It then checks at the next falling edge that every strobe has dropped again. A sweep covers the sixteen combinations of supervisor, enable, debug state and selector, each with both previous-supervisor values. Further cases cover wrap-around of PC+4 and stimulus held while req_valid is low.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;
  typedef enum logic [2:0] {
    RP_NONE,
    RP_USER,
    RP_SUPEN,
    RP_NORM,
    RP_DBG
  } rtn_path_t;
endpackage

// File: rtl/trap_return_capture.sv
module trap_return_capture #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [STAT_W-1:0] status_in,
  input  logic              in_debug,
  input  logic              dbg_sel,
  input  logic [ADDR_W-1:0] trap_pc,
  input  logic [ADDR_W-1:0] dbg_pc,
  input  logic              dbg_save_en,
  input  logic              dbg_save_sup,
  output logic              c_valid,
  output logic [ADDR_W-1:0] c_pc,
  output logic [STAT_W-1:0] c_stat,
  output logic              c_debug,
  output logic              c_sel,
  output logic [ADDR_W-1:0] c_trap_pc,
  output logic [ADDR_W-1:0] c_dbg_pc,
  output logic              c_dse,
  output logic              c_dss
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid <= 1'b0;
    end else begin
      c_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_pc      <= '0;
      c_stat    <= '0;
      c_debug   <= 1'b0;
      c_sel     <= 1'b0;
      c_trap_pc <= '0;
      c_dbg_pc  <= '0;
      c_dse     <= 1'b0;
      c_dss     <= 1'b0;
    end else if (req_valid) begin
      c_pc      <= cur_pc;
      c_stat    <= status_in;
      c_debug   <= in_debug;
      c_sel     <= dbg_sel;
      c_trap_pc <= trap_pc;
      c_dbg_pc  <= dbg_pc;
      c_dse     <= dbg_save_en;
      c_dss     <= dbg_save_sup;
    end
  end
endmodule

// File: rtl/trap_return_decide.sv
module trap_return_decide
  import trap_return_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 8,
  parameter int EN_BIT = 0,
  parameter int SUP_BIT = 1,
  parameter int PSUP_BIT = 2
) (
  input  logic              c_valid,
  input  logic [ADDR_W-1:0] c_pc,
  input  logic [STAT_W-1:0] c_stat,
  input  logic              c_debug,
  input  logic              c_sel,
  input  logic [ADDR_W-1:0] c_trap_pc,
  input  logic [ADDR_W-1:0] c_dbg_pc,
  input  logic              c_dse,
  input  logic              c_dss,
  output logic [ADDR_W-1:0] d_pc,
  output logic [STAT_W-1:0] d_wdata,
  output logic              d_we,
  output logic              d_dclr,
  output logic              d_halt,
  output logic              d_ill
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  rtn_path_t path;
  logic      sup, en, new_en, new_sup;
  logic [ADDR_W-1:0] seq_pc;

  assign sup    = c_stat[SUP_BIT];
  assign en     = c_stat[EN_BIT];
  assign seq_pc = c_pc + STEP;

  always_comb begin
    if (!sup)                   path = RP_USER;
    else if (en)                path = RP_SUPEN;
    else if (!c_debug && !c_sel) path = RP_NORM;
    else if (c_debug && c_sel)  path = RP_DBG;
    else                        path = RP_NONE;
  end

  always_comb begin
    d_pc    = seq_pc;
    new_en  = en;
    new_sup = sup;
    d_we    = 1'b0;
    d_dclr  = 1'b0;
    d_halt  = 1'b0;
    d_ill   = 1'b0;
    unique case (path)
      RP_USER:  d_halt = c_valid & ~en;
      RP_SUPEN: d_ill  = c_valid;
      RP_NORM: begin
        d_pc    = c_trap_pc;
        new_en  = 1'b1;
        new_sup = c_stat[PSUP_BIT];
        d_we    = c_valid;
      end
      RP_DBG: begin
        d_pc    = c_dbg_pc;
        new_en  = c_dse;
        new_sup = c_dss;
        d_we    = c_valid;
        d_dclr  = c_valid;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == EN_BIT) begin : g_en
      assign d_wdata[i] = new_en;
    end else if (i == SUP_BIT) begin : g_sup
      assign d_wdata[i] = new_sup;
    end else begin : g_keep
      assign d_wdata[i] = c_stat[i];
    end
  end
endmodule

// File: rtl/trap_return_outreg.sv
module trap_return_outreg #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_valid,
  input  logic [ADDR_W-1:0] d_pc,
  input  logic [STAT_W-1:0] d_wdata,
  input  logic              d_we,
  input  logic              d_dclr,
  input  logic              d_halt,
  input  logic              d_ill,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              stat_we,
  output logic [STAT_W-1:0] stat_wdata,
  output logic              dbg_clear,
  output logic              halt_req,
  output logic              illegal_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      stat_we     <= 1'b0;
      dbg_clear   <= 1'b0;
      halt_req    <= 1'b0;
      illegal_req <= 1'b0;
    end else begin
      rsp_valid   <= c_valid;
      stat_we     <= c_valid & d_we;
      dbg_clear   <= c_valid & d_dclr;
      halt_req    <= c_valid & d_halt;
      illegal_req <= c_valid & d_ill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc    <= '0;
      stat_wdata <= '0;
    end else if (c_valid) begin
      next_pc    <= d_pc;
      stat_wdata <= d_wdata;
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 8,
  parameter int EN_BIT = 0,
  parameter int SUP_BIT = 1,
  parameter int PSUP_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [STAT_W-1:0] status_in,
  input  logic              in_debug,
  input  logic              dbg_sel,
  input  logic [ADDR_W-1:0] trap_pc,
  input  logic [ADDR_W-1:0] dbg_pc,
  input  logic              dbg_save_en,
  input  logic              dbg_save_sup,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              stat_we,
  output logic [STAT_W-1:0] stat_wdata,
  output logic              dbg_clear,
  output logic              halt_req,
  output logic              illegal_req
);
  logic              c_valid, c_debug, c_sel, c_dse, c_dss;
  logic [ADDR_W-1:0] c_pc, c_trap_pc, c_dbg_pc;
  logic [STAT_W-1:0] c_stat;
  logic [ADDR_W-1:0] d_pc;
  logic [STAT_W-1:0] d_wdata;
  logic              d_we, d_dclr, d_halt, d_ill;

  trap_return_capture #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_cap (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cur_pc(cur_pc),
    .status_in(status_in), .in_debug(in_debug), .dbg_sel(dbg_sel),
    .trap_pc(trap_pc), .dbg_pc(dbg_pc), .dbg_save_en(dbg_save_en),
    .dbg_save_sup(dbg_save_sup), .c_valid(c_valid), .c_pc(c_pc),
    .c_stat(c_stat), .c_debug(c_debug), .c_sel(c_sel),
    .c_trap_pc(c_trap_pc), .c_dbg_pc(c_dbg_pc), .c_dse(c_dse), .c_dss(c_dss)
  );

  trap_return_decide #(
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .EN_BIT(EN_BIT),
    .SUP_BIT(SUP_BIT), .PSUP_BIT(PSUP_BIT)
  ) u_dec (
    .c_valid(c_valid), .c_pc(c_pc), .c_stat(c_stat), .c_debug(c_debug),
    .c_sel(c_sel), .c_trap_pc(c_trap_pc), .c_dbg_pc(c_dbg_pc),
    .c_dse(c_dse), .c_dss(c_dss), .d_pc(d_pc), .d_wdata(d_wdata),
    .d_we(d_we), .d_dclr(d_dclr), .d_halt(d_halt), .d_ill(d_ill)
  );

  trap_return_outreg #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_out (
    .clk(clk), .rst(rst), .c_valid(c_valid), .d_pc(d_pc),
    .d_wdata(d_wdata), .d_we(d_we), .d_dclr(d_dclr), .d_halt(d_halt),
    .d_ill(d_ill), .rsp_valid(rsp_valid), .next_pc(next_pc),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .dbg_clear(dbg_clear),
    .halt_req(halt_req), .illegal_req(illegal_req)
  );
endmodule

// File: rtl/trap_return_checker.sv
module trap_return_checker #(
  parameter int STAT_W = 8,
  parameter int EN_BIT = 0,
  parameter int SUP_BIT = 1,
  parameter int PSUP_BIT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              c_valid,
  input logic [STAT_W-1:0] c_stat,
  input logic              rsp_valid,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_wdata,
  input logic              dbg_clear,
  input logic              halt_req,
  input logic              illegal_req
);
  assert_strobe_in_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_we | dbg_clear | halt_req | illegal_req) |-> rsp_valid);

  assert_capture_stage_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> c_valid);

  assert_result_stage_R2: assert property (@(posedge clk) disable iff (rst)
    c_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !c_valid |=> !rsp_valid);

  assert_one_action_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({halt_req, illegal_req, stat_we}) <= 1);

  assert_dbg_clear_writes_R6: assert property (@(posedge clk) disable iff (rst)
    dbg_clear |-> stat_we);

  assert_norm_restore_R5: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_stat[SUP_BIT] && !c_stat[EN_BIT]) |=>
      (!stat_we || dbg_clear ||
       (stat_wdata[EN_BIT] && stat_wdata[SUP_BIT] == $past(c_stat[PSUP_BIT]))));

  assert_user_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (c_valid && !c_stat[SUP_BIT]) |=> (!stat_we && !illegal_req));
endmodule

bind trap_return_unit trap_return_checker #(
  .STAT_W(STAT_W), .EN_BIT(EN_BIT), .SUP_BIT(SUP_BIT), .PSUP_BIT(PSUP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .c_valid(c_valid),
  .c_stat(c_stat), .rsp_valid(rsp_valid), .stat_we(stat_we),
  .stat_wdata(stat_wdata), .dbg_clear(dbg_clear), .halt_req(halt_req),
  .illegal_req(illegal_req)
);

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;
  localparam int AW = 32;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] cur_pc = '0, trap_pc = '0, dbg_pc = '0;
  logic [SW-1:0] status_in = '0;
  logic in_debug = 1'b0, dbg_sel = 1'b0, dbg_save_en = 1'b0, dbg_save_sup = 1'b0;
  logic rsp_valid, stat_we, dbg_clear, halt_req, illegal_req;
  logic [AW-1:0] next_pc;
  logic [SW-1:0] stat_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trap_return_unit u_trap_return_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cur_pc(cur_pc),
    .status_in(status_in), .in_debug(in_debug), .dbg_sel(dbg_sel),
    .trap_pc(trap_pc), .dbg_pc(dbg_pc), .dbg_save_en(dbg_save_en),
    .dbg_save_sup(dbg_save_sup), .rsp_valid(rsp_valid), .next_pc(next_pc),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .dbg_clear(dbg_clear),
    .halt_req(halt_req), .illegal_req(illegal_req)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flags();
    return {3'b0, rsp_valid, stat_we, dbg_clear, halt_req, illegal_req};
  endfunction

  task automatic run(input bit s, input bit et, input bit ps, input bit dbg,
                     input bit fld, input logic [AW-1:0] pc, input bit dse,
                     input bit dss);
    logic [AW-1:0] e_pc;
    logic [SW-1:0] st, e_wd;
    bit e_we, e_dc, e_h, e_i;
    string tag;
    st = {5'b10101, ps, s, et};
    e_pc = pc + 32'd4; e_wd = st; e_we = 0; e_dc = 0; e_h = 0; e_i = 0;
    if (!s) begin tag = "R3"; e_h = !et; end
    else if (et) begin tag = "R4"; e_i = 1; end
    else if (!dbg && !fld) begin
      tag = "R5"; e_pc = 32'h0000_4000 ^ pc; e_we = 1; e_wd[0] = 1'b1; e_wd[1] = ps;
    end else if (dbg && fld) begin
      tag = "R6"; e_pc = 32'h0000_8000 ^ pc; e_we = 1; e_dc = 1;
      e_wd[0] = dse; e_wd[1] = dss;
    end else tag = "R7";
    @(negedge clk);
    cur_pc = pc; status_in = st; in_debug = dbg; dbg_sel = fld;
    trap_pc = 32'h0000_4000 ^ pc; dbg_pc = 32'h0000_8000 ^ pc;
    dbg_save_en = dse; dbg_save_sup = dss; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cur_pc = ~pc; status_in = ~st;
    @(negedge clk);
    check(rsp_valid === 1'b1, {tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
    check(next_pc === e_pc, {tag, " next_pc"}, 64'(next_pc), 64'(e_pc));
    check(flags() === {3'b0, 1'b1, e_we, e_dc, e_h, e_i}, {tag, " R9 strobes"},
          64'(flags()), 64'({3'b0, 1'b1, e_we, e_dc, e_h, e_i}));
    if (e_we)
      check(stat_wdata === e_wd, {tag, " stat_wdata"}, 64'(stat_wdata), 64'(e_wd));
    @(negedge clk);
    check(flags() === 8'h00, {tag, " R2 pulse ends"}, 64'(flags()), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(flags() === 8'h00, "R1 reset", 64'(flags()), 64'd0);
    rst = 1'b0;
    for (int c = 0; c < 32; c++) begin
      run(c[3], c[2], c[4], c[1], c[0], 32'h1000_0000 + 32'(c * 16), c[0] ^ c[4], c[2] ^ c[4]);
    end
    // R8: PC+4 wraps
    run(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 1'b0, 1'b0);
    run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0);
    check(next_pc === 32'h0, "R8 wrap", 64'(next_pc), 64'd0);
    // R10: inputs without req_valid
    @(negedge clk);
    status_in = 8'b0000_0010; in_debug = 1'b0; dbg_sel = 1'b0; cur_pc = 32'h55;
    repeat (3) begin
      @(negedge clk);
      check(flags() === 8'h00, "R10 idle", 64'(flags()), 64'd0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule